// File: doc/BRIEF.md
# Inter-Processor Interrupt Mask and Trigger Unit

This block is the interrupt register set that one processor uses to receive software-raised and hardware-raised interrupts. A chip places one copy beside each CPU. Each of the 32 interrupt lines has a pending bit and a mask bit. Pending bits are raised by hardware event inputs or by a self-clearing trigger alias. They are lowered by either of two write-1 clear aliases, one for clearing status and one for acknowledging. Mask bits are changed only through separate write-1 set and write-1 clear aliases, so software never needs a read-modify-write sequence.

A single write port carries a write code that selects the alias, together with the data word. A read code selects raw pending bits, pending bits with masked lines removed, the mask itself, or the trigger alias. The trigger alias always reads as zero. Reads never change state. The interrupt line is the OR of all unmasked pending bits, taken through one register stage. When a hardware event arrives in the same cycle as a clear of the same bit, the bit stays pending, so that no event is lost.

Top module: `ipi_unit`

## Requirements
- R1: After reset the mask reads all ones (every line disabled), the raw pending bits read zero and `irq_o` is low.
- R2: A write with code 1 (mask set) sets each mask bit whose data bit is 1 and leaves the bits with data 0 unchanged. Read code 0 returns the mask.
- R3: A write with code 2 (mask clear) clears each mask bit whose data bit is 1 and leaves the others unchanged. A mask bit of 0 enables its line.
- R4: A write with code 3 (status clear) clears each pending bit whose data bit is 1. Data bits of 0 have no effect.
- R5: A write with code 4 (acknowledge) clears pending bits exactly as code 3 does.
- R6: A write with code 5 (trigger) sets each pending bit whose data bit is 1. Data bits of 0 have no effect. Read code 3 (the trigger alias) always returns zero.
- R7: In any cycle where bit i of `evt_i` is high, pending bit i is set at the next clock edge.
- R8: If an event and a clear (code 3 or 4) hit the same bit in the same cycle, that bit is pending afterwards.
- R9: Read code 1 returns the raw pending bits, and repeated reads leave them unchanged.
- R10: Read code 2 returns the pending bits AND NOT the mask.
- R11: `irq_o` equals the OR of all masked-status bits of the previous cycle.
- R12: Writes with codes 0, 6 or 7 change nothing, and read codes 4 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_code | input | 3 | Alias selected by the write (1 mask set, 2 mask clear, 3 status clear, 4 acknowledge, 5 trigger) |
| wr_data | input | 32 | Write-1 data word |
| evt_i | input | 32 | Hardware event levels, one per line |
| rd_code | input | 3 | Read select (0 mask, 1 raw, 2 masked, 3 trigger) |
| rd_data | output | 32 | Read data, combinational from the selected state |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets the collision of an event with a status clear or acknowledge on the same bit. A design that lets the clear win would drop the interrupt and show a zero raw bit where one is expected. It also writes zero data to every alias and uses the unused write codes, to catch an alias that writes its data directly instead of acting only on ones. It checks that the trigger alias reads as zero, and that `irq_o` goes high exactly one cycle after an unmasked bit becomes pending and low one cycle after it is masked or cleared. A missing or extra output register would show as a one-cycle disagreement with the reference model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    WR_NONE     = 3'd0,
    WR_MASK_SET = 3'd1,
    WR_MASK_CLR = 3'd2,
    WR_STS_CLR  = 3'd3,
    WR_ACK      = 3'd4,
    WR_TRIG     = 3'd5,
    WR_RSV6     = 3'd6,
    WR_RSV7     = 3'd7
  } wr_code_e;

  typedef enum logic [CODE_W-1:0] {
    RD_MASK   = 3'd0,
    RD_RAW    = 3'd1,
    RD_MASKED = 3'd2,
    RD_TRIG   = 3'd3,
    RD_RSV4   = 3'd4,
    RD_RSV5   = 3'd5,
    RD_RSV6   = 3'd6,
    RD_RSV7   = 3'd7
  } rd_code_e;

endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  mask_set,
  output logic [WIDTH-1:0]  mask_clr,
  output logic [WIDTH-1:0]  pend_set,
  output logic [WIDTH-1:0]  pend_clr
);

  always_comb begin
    mask_set = '0;
    mask_clr = '0;
    pend_set = '0;
    pend_clr = '0;
    if (wr_en) begin
      case (wr_code)
        WR_MASK_SET: mask_set = wr_data;
        WR_MASK_CLR: mask_clr = wr_data;
        WR_STS_CLR:  pend_clr = wr_data;
        WR_ACK:      pend_clr = wr_data;
        WR_TRIG:     pend_set = wr_data;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/ipi_bit_cell.sv
module ipi_bit_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_set,
  input  logic mask_clr,
  input  logic pend_set,
  input  logic pend_clr,
  input  logic evt,
  output logic mask_q,
  output logic pend_q
);

  logic mask_en;
  logic mask_d;
  logic pend_en;
  logic pend_d;

  // Next state: a set of a pending bit wins over a clear in the same cycle.
  always_comb begin
    mask_en = mask_set | mask_clr;
    mask_d  = mask_set;
    pend_en = pend_set | pend_clr | evt;
    pend_d  = pend_set | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/ipi_irq_gen.sv
module ipi_irq_gen #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] masked,
  output logic             irq_q
);

  logic irq_d;

  always_comb begin
    irq_d = |masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
  import ipi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [CODE_W-1:0] rd_code,
  input  logic [WIDTH-1:0]  mask_q,
  input  logic [WIDTH-1:0]  pend_q,
  input  logic [WIDTH-1:0]  masked,
  output logic [WIDTH-1:0]  rd_data
);

  always_comb begin
    case (rd_code)
      RD_MASK:   rd_data = mask_q;
      RD_RAW:    rd_data = pend_q;
      RD_MASKED: rd_data = masked;
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int RS_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  evt_i,
  input  logic [CODE_W-1:0] rd_code,
  output logic [WIDTH-1:0]  rd_data,
  output logic              irq_o
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] mask_set;
  logic [WIDTH-1:0] mask_clr;
  logic [WIDTH-1:0] pend_set;
  logic [WIDTH-1:0] pend_clr;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] masked;

  ipi_rst_sync #(.STAGES(RS_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipi_wr_decode #(.WIDTH(WIDTH)) u_dec (
    .wr_en    (wr_en),
    .wr_code  (wr_code),
    .wr_data  (wr_data),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .pend_set (pend_set),
    .pend_clr (pend_clr)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    ipi_bit_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .mask_set (mask_set[i]),
      .mask_clr (mask_clr[i]),
      .pend_set (pend_set[i]),
      .pend_clr (pend_clr[i]),
      .evt      (evt_i[i]),
      .mask_q   (mask_q[i]),
      .pend_q   (pend_q[i])
    );
  end

  assign masked = pend_q & ~mask_q;

  ipi_irq_gen #(.WIDTH(WIDTH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .masked (masked),
    .irq_q  (irq_o)
  );

  ipi_read_mux #(.WIDTH(WIDTH)) u_rd (
    .rd_code (rd_code),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .masked  (masked),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
  import ipi_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic [CODE_W-1:0] wr_code,
  input logic [WIDTH-1:0]  wr_data,
  input logic [WIDTH-1:0]  evt_i,
  input logic [CODE_W-1:0] rd_code,
  input logic [WIDTH-1:0]  rd_data,
  input logic              irq_o,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  pend_q
);

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_code == WR_MASK_SET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_code == WR_MASK_CLR) |=> ((mask_q & $past(wr_data)) == '0));

  // R4
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (wr_code == WR_STS_CLR || wr_code == WR_ACK) && ((wr_data & evt_i) == '0))
      |=> ((pend_q & $past(wr_data)) == '0));

  // R8
  evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R6
  trig_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_code == RD_TRIG) |-> (rd_data == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_o == $past((pend_q & ~mask_q) != '0)));

  // R12
  rsv_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (wr_code == WR_NONE || wr_code == WR_RSV6 || wr_code == WR_RSV7))
      |=> (mask_q == $past(mask_q)));

endmodule

bind ipi_unit ipi_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_code    (wr_code),
  .wr_data    (wr_data),
  .evt_i      (evt_i),
  .rd_code    (rd_code),
  .rd_data    (rd_data),
  .irq_o      (irq_o),
  .mask_q     (mask_q),
  .pend_q     (pend_q)
);

// File: tb/sim_ipi_unit.sv
module sim_ipi_unit;

  localparam int  W        = 32;
  localparam time CLK_PER  = 10ns;
  localparam int  WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_code = 3'd0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  evt_i = '0;
  logic [2:0]    rd_code = 3'd0;
  logic [W-1:0]  rd_data;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  // reference model state
  logic [W-1:0] m_mask;
  logic [W-1:0] m_pend;
  logic         m_irq;

  always #(CLK_PER/2) clk = ~clk;

  ipi_unit u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .wr_data (wr_data),
    .evt_i   (evt_i),
    .rd_code (rd_code),
    .rd_data (rd_data),
    .irq_o   (irq_o)
  );

  // Behavioural model from the requirements.
  always @(posedge clk or negedge rst_n) begin
    logic [W-1:0] nm;
    logic [W-1:0] np;
    if (!rst_n) begin
      m_mask <= '1;
      m_pend <= '0;
      m_irq  <= 1'b0;
    end else begin
      nm = m_mask;
      np = m_pend;
      if (wr_en) begin
        if (wr_code == 3'd1) nm = nm | wr_data;
        if (wr_code == 3'd2) nm = nm & ~wr_data;
        if (wr_code == 3'd3 || wr_code == 3'd4) np = np & ~wr_data;
        if (wr_code == 3'd5) np = np | wr_data;
      end
      np = np | evt_i;
      m_irq  <= ((m_pend & ~m_mask) != '0);
      m_mask <= nm;
      m_pend <= np;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_rd(input logic [2:0] c);
    case (c)
      3'd0: return m_mask;
      3'd1: return m_pend;
      3'd2: return m_pend & ~m_mask;
      default: return '0;
    endcase
  endfunction

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      case (rd_code)
        3'd0: chk("R2 mask read vs model", rd_data, exp_rd(rd_code));
        3'd1: chk("R9 raw read vs model", rd_data, exp_rd(rd_code));
        3'd2: chk("R10 masked read vs model", rd_data, exp_rd(rd_code));
        3'd3: chk("R6 trigger read vs model", rd_data, exp_rd(rd_code));
        default: chk("R12 unused read vs model", rd_data, exp_rd(rd_code));
      endcase
      chk("R11 irq vs model", {31'd0, irq_o}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [2:0] code, input logic [W-1:0] data, input logic [W-1:0] ev);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_code = code; wr_data = data; evt_i = ev;
    @(negedge clk); #1;
    wr_en = 1'b0; wr_code = 3'd0; wr_data = '0; evt_i = '0;
  endtask

  task automatic rd_chk(input logic [2:0] code, input logic [W-1:0] exp, input string tag);
    @(negedge clk); #1;
    rd_code = code;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    chk(tag, {31'd0, irq_o}, {31'd0, exp});
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_on = 1'b1;

    // R1 reset state
    rd_chk(3'd0, 32'hFFFF_FFFF, "R1 mask after reset");
    rd_chk(3'd1, 32'h0, "R1 pending after reset");
    irq_chk(1'b0, "R1 irq after reset");

    // R3 then R2
    wr(3'd2, 32'h0000_00F0, '0);
    rd_chk(3'd0, 32'hFFFF_FF0F, "R3 mask clear alias");
    wr(3'd1, 32'h0000_0010, '0);
    rd_chk(3'd0, 32'hFFFF_FF1F, "R2 mask set alias");
    wr(3'd1, 32'h0, '0);
    wr(3'd2, 32'h0, '0);
    rd_chk(3'd0, 32'hFFFF_FF1F, "R2 R3 zero data no effect");

    // R6 trigger
    wr(3'd5, 32'h0000_00A0, '0);
    rd_chk(3'd1, 32'h0000_00A0, "R6 trigger sets pending");
    rd_chk(3'd3, 32'h0, "R6 trigger reads zero");
    rd_chk(3'd2, 32'h0000_00A0, "R10 masked status");
    irq_chk(1'b1, "R11 irq high on unmasked pending");
    rd_chk(3'd1, 32'h0000_00A0, "R9 repeated raw read unchanged");

    // R4 / R5
    wr(3'd3, 32'h0000_0020, '0);
    rd_chk(3'd1, 32'h0000_0080, "R4 status clear");
    wr(3'd4, 32'h0000_0080, '0);
    rd_chk(3'd1, 32'h0, "R5 acknowledge clear");
    irq_chk(1'b0, "R11 irq low after clear");

    // R7 event, masked lines
    wr(3'd0, 32'h0, 32'h0000_0003);
    rd_chk(3'd1, 32'h0000_0003, "R7 event sets pending");
    rd_chk(3'd2, 32'h0, "R10 masked lines hidden");
    irq_chk(1'b0, "R11 irq low when all masked");

    // R8 collision
    wr(3'd3, 32'h0000_0003, 32'h0000_0001);
    rd_chk(3'd1, 32'h0000_0001, "R8 event beats status clear");
    wr(3'd4, 32'h0000_0001, 32'h0000_0001);
    rd_chk(3'd1, 32'h0000_0001, "R8 event beats acknowledge");

    // R12 unused codes
    wr(3'd6, 32'hFFFF_FFFF, '0);
    wr(3'd7, 32'hFFFF_FFFF, '0);
    wr(3'd0, 32'h0000_0000, '0);
    rd_chk(3'd0, 32'hFFFF_FF1F, "R12 unused write keeps mask");
    rd_chk(3'd1, 32'h0000_0001, "R12 unused write keeps pending");
    rd_chk(3'd5, 32'h0, "R12 unused read code");

    // R3 unmask -> R11
    wr(3'd2, 32'h0000_0001, '0);
    rd_chk(3'd2, 32'h0000_0001, "R3 R10 unmasked line visible");
    irq_chk(1'b1, "R11 irq after unmask");

    // Random phase, compared every cycle against the model.
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      @(negedge clk); #1;
      r = $urandom;
      wr_en   = r[0];
      wr_code = r[3:1];
      rd_code = r[6:4];
      wr_data = (r[7]) ? $urandom : ($urandom & $urandom);
      evt_i   = r[8] ? ($urandom & $urandom & $urandom) : '0;
    end
    @(negedge clk); #1;
    wr_en = 1'b0; evt_i = '0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule